// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Add-One Converters

This block adds two unsigned WIDTH-bit operands and a carry-in and returns a WIDTH-bit sum and a carry-out, with no clock and no state. The word is cut into groups that grow by one bit from group to group. The lowest group is a plain ripple adder fed by the external carry-in. Every higher group is a select group: a ripple adder forms its result on the assumption that the incoming carry is 0. An add-one converter then turns that result into the result for an incoming carry of 1. A per-group multiplexer picks one of the two, steered by the carry leaving the group below.

Each select group uses the converter in place of a second ripple adder. The converter is narrower in gates, and the carry chain between groups still passes only through one multiplexer per group. The default width is 16 bits. The group layout is derived from WIDTH, so the same source builds wider adders up to 256 bits.

Top module: `sqcs_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout, sum} equals a + b + cin as an unsigned (WIDTH+1)-bit value.
- R2: The lowest group covers bits [1:0] and is a ripple adder whose carry-in is the external cin.
- R3: Each select group forms a ripple result (sum bits and carry) with its group carry-in taken as 0, every full adder taking the carry of the bit just below.
- R4: Each select group's carry-1 candidate equals its (n+1)-bit carry-0 candidate plus one, produced by a converter in which bit i is inverted exactly when all lower bits are 1, wrapping to zero when all are 1.
- R5: A select group outputs its carry-0 candidate when the carry leaving the group below is 0 and its carry-1 candidate when that carry is 1, so a carry crossing any group boundary lands correctly in the sum.
- R6: With WIDTH = 16 the groups are bits [1:0], [3:2], [6:4], [10:7] and [15:11].
- R7: For other widths the group sizes run 2, 2, 3, 4, ... growing by one per group, and the last group is cut short so the sizes add up to exactly WIDTH (WIDTH = 10 gives 2, 2, 3, 3).
- R8: cout is the carry chosen by the highest group's multiplexer; all-ones operands with cin = 1 give an all-ones sum and cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
Because the block has no state, a wrong internal value shows at once: the sum bits of the faulty group, or of every group above a wrong select carry, differ from a + b + cin within the same evaluation. The bench walks a carry into each group boundary so that a wrong multiplexer select line or a wrong converter bit appears in exactly one group's sum bits. A misplaced boundary for a derived width shows up the same way in the 10-bit and 32-bit instances.

// File: rtl/sqcs_pkg.sv
package sqcs_pkg;

  // Untruncated size of group k: 2, 2, 3, 4, 5, ...
  function automatic int grp_raw(input int k);
    return (k == 0) ? 2 : k + 1;
  endfunction

  // Number of groups needed to cover a word of width n
  function automatic int grp_count(input int n);
    int acc;
    int g;
    acc = 0;
    g = 0;
    while (acc < n) begin
      acc += grp_raw(g);
      g++;
    end
    return g;
  endfunction

  // Lowest bit index of group k
  function automatic int grp_lo(input int n, input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += grp_raw(j);
    return (acc > n) ? n : acc;
  endfunction

  // Size of group k, last one cut to fit
  function automatic int grp_size(input int n, input int k);
    int rest;
    rest = n - grp_lo(n, k);
    return (grp_raw(k) < rest) ? grp_raw(k) : rest;
  endfunction

endpackage

// File: rtl/sqcs_ripple.sv
module sqcs_ripple #(
  parameter int W = 2
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end

  assign co = c[W];

  // Ripple chain result matches arithmetic addition
  always_comb begin
    if (!$isunknown({x, y, ci}))
      assert_ripple_sum_R3: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci}))
        else $error("ripple chain mismatch");
  end

endmodule

// File: rtl/sqcs_excess1.sv
module sqcs_excess1 #(
  parameter int W = 3
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] inc
);

  logic [W:0] all_low;

  always_comb begin
    all_low[0] = 1'b1;
    for (int i = 0; i < W; i++) begin
      inc[i]       = src[i] ^ all_low[i];
      all_low[i+1] = all_low[i] & src[i];
    end
  end

  // Converter output is its input plus one, wrapping
  always_comb begin
    if (!$isunknown(src))
      assert_plus_one_R4: assert (inc == W'(src + 1'b1))
        else $error("add-one converter mismatch");
  end

endmodule

// File: rtl/sqcs_select_group.sv
module sqcs_select_group #(
  parameter int W = 2
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W-1:0] s_zero;
  logic         c_zero;
  logic [W:0]   cand_one;

  sqcs_ripple #(.W(W)) u_rca (
    .x  (x),
    .y  (y),
    .ci (1'b0),
    .s  (s_zero),
    .co (c_zero)
  );

  sqcs_excess1 #(.W(W + 1)) u_bec (
    .src ({c_zero, s_zero}),
    .inc (cand_one)
  );

  assign {co, s} = sel ? cand_one : {c_zero, s_zero};

  // A carry-0 carry-out implies a carry-1 carry-out
  always_comb begin
    if (!$isunknown({x, y}))
      assert_carry_order_R4: assert (!c_zero || cand_one[W])
        else $error("carry-1 candidate lost its carry");
  end

  // Selected output equals the group sum with the select as carry-in
  always_comb begin
    if (!$isunknown({x, y, sel}))
      assert_group_pick_R5: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, sel}))
        else $error("group selection mismatch");
  end

endmodule

// File: rtl/sqcs_adder.sv
module sqcs_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import sqcs_pkg::*;

  localparam int NGRP = grp_count(WIDTH);
  localparam int LOW_W = grp_size(WIDTH, 0);

  logic [NGRP:0] gcar;

  sqcs_ripple #(.W(LOW_W)) u_low (
    .x  (a[LOW_W-1:0]),
    .y  (b[LOW_W-1:0]),
    .ci (cin),
    .s  (sum[LOW_W-1:0]),
    .co (gcar[1])
  );
  assign gcar[0] = cin;

  for (genvar k = 1; k < NGRP; k++) begin : g_sel
    localparam int LO = grp_lo(WIDTH, k);
    localparam int SZ = grp_size(WIDTH, k);
    sqcs_select_group #(.W(SZ)) u_grp (
      .x   (a[LO+SZ-1:LO]),
      .y   (b[LO+SZ-1:LO]),
      .sel (gcar[k]),
      .s   (sum[LO+SZ-1:LO]),
      .co  (gcar[k+1])
    );
  end

  assign cout = gcar[NGRP];

  // End-to-end result equals a + b + cin
  always_comb begin
    if (!$isunknown({a, b, cin}))
      assert_total_sum_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
        else $error("adder total mismatch");
  end

  // All-ones operands with carry-in give all-ones sum and carry
  always_comb begin
    if (!$isunknown({a, b, cin}) && (&a) && (&b) && cin)
      assert_top_carry_R8: assert (cout && (&sum))
        else $error("top carry wrong");
  end

endmodule

// File: tb/sqcs_adder_tb.sv
module sqcs_adder_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] a16, b16, s16;
  logic        c16, co16;
  logic [31:0] a32, b32, s32;
  logic        c32, co32;
  logic [9:0]  a10, b10, s10;
  logic        c10, co10;

  sqcs_adder #(.WIDTH(16)) u_dut (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
  sqcs_adder #(.WIDTH(32)) u_dut_w (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
  sqcs_adder #(.WIDTH(10)) u_dut_t (.a(a10), .b(b10), .cin(c10), .sum(s10), .cout(co10));

  function automatic logic [32:0] ref_add(input logic [31:0] x, input logic [31:0] y,
                                          input logic ci, input int w);
    logic [32:0] full;
    logic [32:0] mask;
    full = {1'b0, x} + {1'b0, y} + {32'd0, ci};
    mask = (33'd1 << (w + 1)) - 33'd1;
    return full & mask;
  endfunction

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run16(input string tag, input logic [15:0] x, input logic [15:0] y, input logic ci);
    @(negedge clk);
    a16 = x; b16 = y; c16 = ci;
    #2;
    check(tag, {16'd0, co16, s16}, ref_add({16'd0, x}, {16'd0, y}, ci, 16));
  endtask

  task automatic run32(input string tag, input logic [31:0] x, input logic [31:0] y, input logic ci);
    @(negedge clk);
    a32 = x; b32 = y; c32 = ci;
    #2;
    check(tag, {co32, s32}, ref_add(x, y, ci, 32));
  endtask

  task automatic run10(input string tag, input logic [9:0] x, input logic [9:0] y, input logic ci);
    @(negedge clk);
    a10 = x; b10 = y; c10 = ci;
    #2;
    check(tag, {22'd0, co10, s10}, ref_add({22'd0, x}, {22'd0, y}, ci, 10));
  endtask

  initial begin
    int unused_seed;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    a10 = '0; b10 = '0; c10 = 1'b0;
    unused_seed = $urandom(32'd2024);

    // Zero inputs give zero result (R1)
    run16("R1 zero", 16'h0000, 16'h0000, 1'b0);
    // Carry-in alone enters the lowest group (R2)
    run16("R2 cin only", 16'h0000, 16'h0000, 1'b1);
    run16("R2 low carry", 16'h0003, 16'h0000, 1'b1);
    // Select group ripple with no incoming carry (R3)
    run16("R3 group ripple", 16'h0550, 16'h02A0, 1'b0);
    // Carry crossing each 16-bit boundary at 2, 4, 7, 11 (R5, R6)
    run16("R6 boundary 2", 16'h0003, 16'h0001, 1'b0);
    run16("R6 boundary 4", 16'h000F, 16'h0001, 1'b0);
    run16("R6 boundary 7", 16'h007F, 16'h0001, 1'b0);
    run16("R6 boundary 11", 16'h07FF, 16'h0001, 1'b0);
    // Converter wrap: group all ones plus carry (R4)
    run16("R4 wrap group", 16'h0070, 16'h0000, 1'b0);
    run16("R4 wrap carry", 16'h007C, 16'h0004, 1'b1);
    // Carry walk through every bit (R5)
    for (int k = 0; k < 16; k++)
      run16("R5 carry walk", 16'((32'd1 << k) - 1), 16'h0000, 1'b1);
    // Alternating patterns (R1)
    run16("R1 alt", 16'hAAAA, 16'h5555, 1'b0);
    run16("R1 alt cin", 16'hAAAA, 16'h5555, 1'b1);
    run16("R1 alt same", 16'hAAAA, 16'hAAAA, 1'b1);
    // All ones (R8)
    run16("R8 all ones", 16'hFFFF, 16'hFFFF, 1'b1);
    run16("R8 top carry", 16'h8000, 16'h8000, 1'b0);
    // Random (R1)
    for (int i = 0; i < 400; i++)
      run16("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));

    // Wider and truncated layouts (R7)
    for (int k = 0; k < 32; k++)
      run32("R7 w32 carry walk", 32'((64'd1 << k) - 1), 32'd0, 1'b1);
    run32("R7 w32 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    for (int i = 0; i < 300; i++)
      run32("R7 w32 random", $urandom, $urandom, 1'($urandom));
    for (int k = 0; k < 10; k++)
      run10("R7 w10 carry walk", 10'((32'd1 << k) - 1), 10'd0, 1'b1);
    run10("R7 w10 last group", 10'h380, 10'h080, 1'b0);
    run10("R8 w10 all ones", 10'h3FF, 10'h3FF, 1'b1);
    for (int i = 0; i < 200; i++)
      run10("R7 w10 random", 10'($urandom), 10'($urandom), 1'($urandom));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule